// File: doc/BRIEF.md
# Ping-pong stream buffer controller

This block lands a continuous stream of samples in two equal on-chip buffers, taking them in turn. While the stream side fills one buffer, a processor reads the other through a read port. The processor does not copy any sample itself. The stream uses a valid/ready handshake. Each buffer holds `BLOCK_LEN` samples in a register array inside the block.

When the stream side writes the last slot of its buffer, the two buffers trade owners. The block then raises a one-cycle interrupt, so the processor knows a complete block is waiting. The processor answers with an acknowledge. If the next block completes while the previous interrupt is still unacknowledged, the controller stops before that final write. It drops ready, raises a sticky overrun flag and waits for the acknowledge. The processor-side block is therefore never overwritten.

Top module: `pp_stream_buf`

## Requirements
- R1: Reset state: `proc_buf` is 1 (the processor owns buffer 1 and the stream fills buffer 0), `irq` is 0, `overrun` is 0 and `s_ready` is 1. The first accepted sample goes to slot 0.
- R2: A sample is accepted on a rising clock edge where `s_valid` and `s_ready` are both 1. Accepted samples are written to the stream-owned buffer at consecutive slots 0, 1, …, `BLOCK_LEN`-1. No processor action is needed to accept them.
- R3: The edge that accepts the `BLOCK_LEN`-th sample of a block exchanges the two buffers. `proc_buf` shows the new processor buffer from that edge on.
- R4: `irq` is high for exactly the one cycle after each exchange, and for no other cycle.
- R5: `rd_data` is a combinational read of the processor-owned buffer at slot `rd_addr` mod `BLOCK_LEN`. Stream writes never change what the processor reads.
- R6: `irq_ack` clears a pending interrupt. An acknowledge while nothing is pending has no effect.
- R7: While an interrupt is pending and the next accepted sample would be the last of its block, `s_ready` is 0 and no sample is accepted. Any cycle in this state with `s_valid` high sets `overrun`.
- R8: After an acknowledge in a stalled state, `s_ready` is 1 from the following cycle. The held sample is then accepted and the exchange proceeds.
- R9: Once set, `overrun` stays 1 until reset.
- R10: Both buffers read as zero after reset, until they are written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Stream sample valid |
| s_data | input | DATA_W | Stream sample |
| s_ready | output | 1 | Controller can accept a sample |
| rd_addr | input | RA_W | Processor read address, folded modulo BLOCK_LEN |
| rd_data | output | DATA_W | Processor-buffer data at the folded address |
| irq | output | 1 | One-cycle block-complete interrupt |
| irq_ack | input | 1 | Processor acknowledge of the interrupt |
| proc_buf | output | 1 | Index of the buffer owned by the processor |
| overrun | output | 1 | Sticky flag: a block completed before the acknowledge |

## Verification
The stream is driven with three patterns, each aimed at a different fault:
- Back-to-back samples separate an off-by-one in the slot counter from a correct exchange.
- Valid gaps show whether an idle cycle advances the counter.
- A withheld acknowledge exposes a controller that overwrites the processor's block instead of stalling.

During streaming the read address also sweeps past `BLOCK_LEN`. This checks the modulo fold and confirms that writes never leak into the processor buffer. Finally, acknowledges with nothing pending and a second reset show that stray acknowledges are ignored and that the overrun flag is both sticky and cleared by reset.

// File: rtl/pp_pkg.sv
package pp_pkg;

    // Identity of one of the two sample buffers.
    typedef enum logic {
        BANK_0 = 1'b0,
        BANK_1 = 1'b1
    } bank_e;

    // Other bank of the pair.
    function automatic bank_e bank_other(input bank_e b);
        return (b == BANK_0) ? BANK_1 : BANK_0;
    endfunction

    // Index width for a count of entries (at least one bit).
    function automatic int unsigned idx_bits(input int unsigned entries);
        return (entries > 1) ? $clog2(entries) : 1;
    endfunction

endpackage

// File: rtl/pp_addr_fold.sv
module pp_addr_fold #(
    parameter int unsigned RA_W      = 5,
    parameter int unsigned BLOCK_LEN = 6,
    parameter int unsigned IDX_W     = 3
) (
    input  logic [RA_W-1:0]  addr_in,
    output logic [IDX_W-1:0] idx_out
);

    localparam bit IS_POW2 = ((BLOCK_LEN & (BLOCK_LEN - 1)) == 0);

    generate
        if (IS_POW2) begin : g_mask
            // Power-of-two length: the low bits are the remainder.
            logic [RA_W+IDX_W-1:0] wide;
            always_comb begin
                wide    = {{IDX_W{1'b0}}, addr_in};
                idx_out = wide[IDX_W-1:0];
            end
        end else begin : g_mod
            // Other lengths: true remainder.
            logic [31:0] rem;
            always_comb begin
                rem     = 32'(addr_in) % 32'(BLOCK_LEN);
                idx_out = rem[IDX_W-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/pp_bank.sv
module pp_bank #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 6,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    mem_d[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = mem_q[i];
            end
        end
    end

endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
    import pp_pkg::*;
#(
    parameter int unsigned BLOCK_LEN = 6,
    parameter int unsigned IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    input  logic             irq_ack,
    output logic             s_ready,
    output logic             wr_en,
    output bank_e            fill_bank,
    output logic [IDX_W-1:0] wr_idx,
    output logic             irq,
    output logic             overrun
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_LEN - 1);

    typedef struct packed {
        bank_e            fill;
        logic [IDX_W-1:0] widx;
        logic             pend;
        logic             irq;
        logic             ovr;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  at_last;
    logic  blocked;
    logic  accept;
    logic  swap;

    always_comb begin
        at_last = (st_q.widx == LAST_IDX);
        blocked = at_last && st_q.pend;
        accept  = s_valid && !blocked;
        swap    = accept && at_last;

        st_d     = st_q;
        st_d.irq = swap;

        if (accept) begin
            st_d.widx = at_last ? '0 : st_q.widx + 1'b1;
        end
        if (swap) begin
            st_d.fill = bank_other(st_q.fill);
        end

        st_d.pend = (st_q.pend && !irq_ack) || swap;

        if (s_valid && blocked) begin
            st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fill: BANK_0, widx: '0, pend: 1'b0, irq: 1'b0, ovr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign s_ready   = !blocked;
    assign wr_en     = accept;
    assign fill_bank = st_q.fill;
    assign wr_idx    = st_q.widx;
    assign irq       = st_q.irq;
    assign overrun   = st_q.ovr;

endmodule

// File: rtl/pp_stream_buf.sv
module pp_stream_buf
    import pp_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned BLOCK_LEN = 6,
    parameter int unsigned RA_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    input  logic [RA_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    input  logic              irq_ack,
    output logic              proc_buf,
    output logic              overrun
);

    localparam int unsigned IDX_W  = idx_bits(BLOCK_LEN);
    localparam int unsigned NBANKS = 2;

    logic              wr_en;
    bank_e             fill_bank;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] bank_rd [NBANKS];

    pp_ctrl #(
        .BLOCK_LEN (BLOCK_LEN),
        .IDX_W     (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .irq_ack   (irq_ack),
        .s_ready   (s_ready),
        .wr_en     (wr_en),
        .fill_bank (fill_bank),
        .wr_idx    (wr_idx),
        .irq       (irq),
        .overrun   (overrun)
    );

    pp_addr_fold #(
        .RA_W      (RA_W),
        .BLOCK_LEN (BLOCK_LEN),
        .IDX_W     (IDX_W)
    ) u_fold (
        .addr_in (rd_addr),
        .idx_out (rd_idx)
    );

    generate
        for (genvar b = 0; b < NBANKS; b++) begin : g_bank
            logic bank_we;
            assign bank_we = wr_en && (fill_bank == bank_e'(b));
            pp_bank #(
                .DATA_W (DATA_W),
                .DEPTH  (BLOCK_LEN),
                .IDX_W  (IDX_W)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (bank_we),
                .wr_idx  (wr_idx),
                .wr_data (s_data),
                .rd_idx  (rd_idx),
                .rd_data (bank_rd[b])
            );
        end
    endgenerate

    // The processor owns whichever bank is not being filled.
    assign proc_buf = (fill_bank == BANK_0);
    assign rd_data  = proc_buf ? bank_rd[1] : bank_rd[0];

endmodule

// File: rtl/pp_stream_buf_chk.sv
module pp_stream_buf_chk #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned BLOCK_LEN = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_valid,
    input logic              s_ready,
    input logic              irq,
    input logic              irq_ack,
    input logic              proc_buf,
    input logic              overrun,
    input logic [DATA_W-1:0] s_data
);

    logic        acc;
    int unsigned acc_cnt;
    logic        pend_c;

    assign acc = s_valid && s_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_cnt <= 0;
            pend_c  <= 1'b0;
        end else begin
            if (acc) begin
                acc_cnt <= (acc_cnt == BLOCK_LEN - 1) ? 0 : acc_cnt + 1;
            end
            pend_c <= irq || (pend_c && !irq_ack);
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (proc_buf && !irq && !overrun && s_ready));

    // R3
    swap_with_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(acc && acc_cnt == BLOCK_LEN - 1));

    // R3
    owner_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_buf != $past(proc_buf)) |-> irq);

    // R4
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7
    stall_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_ready |-> pend_c);

    // R7
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(s_valid && !s_ready));

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R2
    data_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> !$isunknown(s_data));

endmodule

bind pp_stream_buf pp_stream_buf_chk #(
    .DATA_W    (DATA_W),
    .BLOCK_LEN (BLOCK_LEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .irq      (irq),
    .irq_ack  (irq_ack),
    .proc_buf (proc_buf),
    .overrun  (overrun),
    .s_data   (s_data)
);

// File: tb/sim_pp_stream_buf.sv
`timescale 1ns/1ps
module sim_pp_stream_buf;

    localparam int DATA_W = 16;
    localparam int N      = 6;
    localparam int RA_W   = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              s_valid = 1'b0;
    logic [DATA_W-1:0] s_data = '0;
    logic              s_ready;
    logic [RA_W-1:0]   rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              irq;
    logic              irq_ack = 1'b0;
    logic              proc_buf;
    logic              overrun;

    int n_chk = 0;
    int n_err = 0;
    int seq   = 0;

    always #4 clk = ~clk;

    pp_stream_buf #(.DATA_W(DATA_W), .BLOCK_LEN(N), .RA_W(RA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .irq_ack(irq_ack), .proc_buf(proc_buf), .overrun(overrun)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [DATA_W-1:0] m_mem [2][N];
    int  m_fill, m_idx;
    bit  m_pend, m_ovr, m_irq, m_live;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int i = 0; i < N; i++) m_mem[b][i] = '0;
            m_fill = 0; m_idx = 0; m_pend = 0; m_ovr = 0; m_irq = 0;
            m_live = 1;
        end else if (m_live) begin
            bit rdy, acc, sw;
            rdy = !(m_idx == N - 1 && m_pend);
            acc = s_valid && rdy;
            sw  = acc && (m_idx == N - 1);
            if (s_valid && !rdy) m_ovr = 1;
            if (acc) begin
                m_mem[m_fill][m_idx] = s_data;
                m_idx = sw ? 0 : m_idx + 1;
            end
            m_pend = (m_pend && !irq_ack) || sw;
            if (sw) m_fill = 1 - m_fill;
            m_irq = sw;
        end
    end

    always @(negedge clk) begin
        if (rst_n && m_live) begin
            chk("R2 R7 R8 s_ready", 32'(s_ready), 32'(!(m_idx == N - 1 && m_pend)));
            chk("R4 R6 irq",        32'(irq),     32'(m_irq));
            chk("R3 proc_buf",      32'(proc_buf), 32'(1 - m_fill));
            chk("R7 R9 overrun",    32'(overrun), 32'(m_ovr));
            chk("R5 R10 rd_data",   32'(rd_data), 32'(m_mem[1 - m_fill][int'(rd_addr) % N]));
        end
    end

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    function automatic logic [DATA_W-1:0] sample_val(input int k);
        return DATA_W'(k * 37 + 5);
    endfunction

    task automatic push(input int gap);
        s_valid = 1'b1;
        s_data  = sample_val(seq);
        while (!s_ready) cyc();
        cyc();
        seq++;
        s_valid = 1'b0;
        rd_addr = rd_addr + 1'b1;
        repeat (gap) cyc();
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        cyc();
        irq_ack = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        int base;
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 s_ready", 32'(s_ready), 32'd1);
        chk("R1 proc_buf", 32'(proc_buf), 32'd1);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 overrun", 32'(overrun), 32'd0);
        // R10 zeros after reset
        for (int a = 0; a < N; a++) begin
            rd_addr = RA_W'(a); #1;
            chk("R10 zero buffer", 32'(rd_data), 32'd0);
        end
        cyc();

        // Block 0: back-to-back samples
        for (int k = 0; k < N; k++) push(0);
        @(negedge clk);
        chk("R4 irq after block", 32'(irq), 32'd1);
        chk("R3 owner swapped", 32'(proc_buf), 32'd0);
        // R2/R5: read back block 0, including folded addresses
        for (int a = 0; a < 2 * N; a++) begin
            rd_addr = RA_W'(a); #1;
            chk("R2 R5 readback", 32'(rd_data), 32'(sample_val(a % N)));
        end
        cyc();
        ack_pulse();

        // Block 1: gapped valid pattern, no acknowledge afterwards
        for (int k = 0; k < N; k++) push(k % 3);
        // Block 2: stall on last sample
        for (int k = 0; k < N - 1; k++) push(0);
        s_valid = 1'b1; s_data = sample_val(seq);
        repeat (4) begin
            @(negedge clk);
            chk("R7 stalled ready", 32'(s_ready), 32'd0);
            cyc();
        end
        @(negedge clk);
        chk("R7 overrun set", 32'(overrun), 32'd1);
        cyc();
        ack_pulse();
        @(negedge clk);
        chk("R8 ready after ack", 32'(s_ready), 32'd1);
        cyc();
        seq++;
        s_valid = 1'b0;
        @(negedge clk);
        chk("R8 swap after stall", 32'(irq), 32'd1);
        cyc();
        ack_pulse();

        // R6: acknowledges with nothing pending
        ack_pulse();
        ack_pulse();
        @(negedge clk);
        chk("R6 stray ack no irq", 32'(irq), 32'd0);
        cyc();

        // Several blocks with prompt acknowledge
        for (int blk = 0; blk < 3; blk++) begin
            for (int k = 0; k < N; k++) push(blk == 1 ? 1 : 0);
            ack_pulse();
        end
        @(negedge clk);
        chk("R9 overrun still set", 32'(overrun), 32'd1);
        cyc();

        do_reset();
        @(negedge clk);
        chk("R1 overrun cleared by reset", 32'(overrun), 32'd0);
        chk("R1 proc_buf after reset", 32'(proc_buf), 32'd1);
        cyc();
        repeat (2) cyc();
        finish_run();
    end

endmodule